// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a running time of day split into a seconds count and a 31-bit sub-second count, stepped on every cycle of a precision time reference clock. The sub-second field can wrap in one of two ways: as a binary fraction of a second, or as whole nanoseconds, after 999,999,999. The amount added per cycle comes from a small programmed increment. It is applied either on every cycle (coarse method) or only on cycles where a 32-bit frequency-trim accumulator overflows (fine method). The accumulator gains a programmed addend on every cycle.

Software drives four request pulses: load the time, shift the time by a signed offset, reload the addend, and arm a target-time alarm. Each request sets a busy flag. The flag clears itself on the next clock edge, when the action takes place. The value inputs are sampled on that edge. Once armed, the alarm gives a one-cycle interrupt pulse as soon as the running time is strictly later than the target time, and then disarms itself.

Top module: `ptp_systime`

## Requirements
- R1: After reset, sys_sec, sys_sub, the accumulator, the stored addend, every busy flag, trig_armed and trig_irq are all zero.
- R2: In coarse mode (fine_mode=0), with time_en=1 and no load or offset taking effect, sys_sub grows by sub_inc on every clock edge.
- R3: With dec_rollover=0, a sub-second sum above 0x7FFF_FFFF has 0x8000_0000 subtracted from it, and sys_sec increments on the same edge.
- R4: With dec_rollover=1, a sub-second sum above 0x3B9A_C9FF (999,999,999) has 1,000,000,000 subtracted from it, and sys_sec increments on the same edge.
- R5: While time_en=0, sys_sec and sys_sub hold, except when a load or an offset takes effect.
- R6: In fine mode (fine_mode=1) with time_en=1, each edge adds the stored addend to a 32-bit accumulator. sys_sub grows by sub_inc only on edges where that addition carries out of bit 31.
- R7: addend_req sets addend_busy for exactly one cycle. On the edge that clears the flag, addend_in is copied into the stored addend.
- R8: init_req sets init_busy for exactly one cycle. On the edge that clears the flag, sys_sec takes set_sec and sys_sub takes set_sub[30:0].
- R9: update_req sets update_busy for exactly one cycle. On the edge that clears the flag, if set_sub[31]=0, set_sec and set_sub[30:0] are added to the time, with a carry into the seconds across the selected wrap point.
- R10: When set_sub[31]=1, the offset is subtracted instead. If the sub-second field is smaller than set_sub[30:0], one extra second is borrowed and the wrap span is added back into the sub-second field.
- R11: A request that arrives while its own busy flag is set is ignored: it neither extends the flag nor causes a second action.
- R12: If init_busy and update_busy are set together, the load is applied and the offset is discarded without effect.
- R13: trig_req arms the alarm (trig_armed=1) if it is not already armed. While armed, if the registered time {sys_sec, sys_sub} is strictly greater than {target_sec, target_sub}, the next edge raises trig_irq for one cycle and clears trig_armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_en | input | 1 | Run the time counter |
| dec_rollover | input | 1 | 1: wrap at 999,999,999; 0: wrap at 0x7FFF_FFFF |
| fine_mode | input | 1 | 1: accumulator-gated stepping; 0: step every cycle |
| init_req | input | 1 | Request to load the time |
| update_req | input | 1 | Request to apply a signed offset |
| addend_req | input | 1 | Request to reload the addend |
| trig_req | input | 1 | Request to arm the target-time alarm |
| set_sec | input | SEC_W | Seconds value or offset |
| set_sub | input | 32 | Bit 31 sign (1 = subtract), bits 30:0 sub-second value or offset |
| addend_in | input | ACC_W | Addend value for the fine method |
| sub_inc | input | INC_W | Sub-second step |
| target_sec | input | SEC_W | Alarm seconds |
| target_sub | input | 31 | Alarm sub-seconds |
| sys_sec | output | SEC_W | Current seconds |
| sys_sub | output | 31 | Current sub-seconds |
| init_busy | output | 1 | Load pending |
| update_busy | output | 1 | Offset pending |
| addend_busy | output | 1 | Addend reload pending |
| trig_armed | output | 1 | Alarm armed |
| trig_irq | output | 1 | One-cycle alarm pulse |

## Verification
A load request and an offset request can be pending in the same cycle. The bench raises both pulses on one edge, using values that make the two outcomes easy to tell apart. It then requires the loaded time to stay in place and the offset flag to be gone one cycle later. A repeated request while its own flag is still set is also provoked, with the value inputs changed between the two pulses. The bench then checks that the time reflects only one load, followed by a normal step. A cycle-level reference model tracks time, flags and the alarm on every edge, so a rollover that coincides with an alarm firing is judged against the same model.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

    localparam int SUB_W = 31;
    localparam logic [SUB_W-1:0] BIN_MAX = 31'h7FFF_FFFF;
    localparam logic [SUB_W-1:0] DEC_MAX = 31'h3B9A_C9FF;

    typedef struct packed {
        logic             carry;
        logic [SUB_W-1:0] val;
    } wrap_t;

    function automatic logic [SUB_W:0] wrap_span(input logic dec);
        return {1'b0, (dec ? DEC_MAX : BIN_MAX)} + {{SUB_W{1'b0}}, 1'b1};
    endfunction

    // a + b, folded back below the wrap point; carry marks a seconds step
    function automatic wrap_t wrap_add(input logic [SUB_W-1:0] a,
                                       input logic [SUB_W-1:0] b,
                                       input logic dec);
        wrap_t r;
        logic [SUB_W:0] sum;
        logic [SUB_W:0] span;
        span = wrap_span(dec);
        sum  = {1'b0, a} + {1'b0, b};
        if (sum >= span) begin
            r.carry = 1'b1;
            r.val   = SUB_W'(sum - span);
        end else begin
            r.carry = 1'b0;
            r.val   = sum[SUB_W-1:0];
        end
        return r;
    endfunction

    // a - b, borrowing one wrap span when b exceeds a; carry marks a borrow
    function automatic wrap_t wrap_sub(input logic [SUB_W-1:0] a,
                                       input logic [SUB_W-1:0] b,
                                       input logic dec);
        wrap_t r;
        if (a >= b) begin
            r.carry = 1'b0;
            r.val   = a - b;
        end else begin
            r.carry = 1'b1;
            r.val   = SUB_W'({1'b0, a} + wrap_span(dec) - {1'b0, b});
        end
        return r;
    endfunction

endpackage

// File: rtl/ptp_step_gen.sv
module ptp_step_gen #(
    parameter int ACC_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fine,
    input  logic             load,
    input  logic [ACC_W-1:0] addend_in,
    input  logic [INC_W-1:0] sub_inc,
    output logic [INC_W-1:0] step
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] addend;
    } acc_t;

    acc_t           st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, st_q.addend};
        if (run) begin
            st_d.acc = sum[ACC_W-1:0];
        end
        if (load) begin
            st_d.addend = addend_in;
        end
        if (fine) begin
            step = sum[ACC_W] ? sub_inc : '0;
        end else begin
            step = sub_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptp_trigger.sv
module ptp_trigger #(
    parameter int SEC_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm_req,
    input  logic [SEC_W-1:0]          cur_sec,
    input  logic [ptp_pkg::SUB_W-1:0] cur_sub,
    input  logic [SEC_W-1:0]          tgt_sec,
    input  logic [ptp_pkg::SUB_W-1:0] tgt_sub,
    output logic                      armed,
    output logic                      irq
);

    typedef struct packed {
        logic armed;
        logic irq;
    } trig_t;

    trig_t st_d, st_q;
    logic  past_target;

    always_comb begin
        past_target = {cur_sec, cur_sub} > {tgt_sec, tgt_sub};
        st_d        = st_q;
        st_d.irq    = st_q.armed && past_target;
        if (st_q.armed) begin
            st_d.armed = !past_target;
        end else begin
            st_d.armed = arm_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign irq   = st_q.irq;

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime #(
    parameter int SEC_W = 32,
    parameter int ACC_W = 32,
    parameter int INC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      time_en,
    input  logic                      dec_rollover,
    input  logic                      fine_mode,
    input  logic                      init_req,
    input  logic                      update_req,
    input  logic                      addend_req,
    input  logic                      trig_req,
    input  logic [SEC_W-1:0]          set_sec,
    input  logic [31:0]               set_sub,
    input  logic [ACC_W-1:0]          addend_in,
    input  logic [INC_W-1:0]          sub_inc,
    input  logic [SEC_W-1:0]          target_sec,
    input  logic [ptp_pkg::SUB_W-1:0] target_sub,
    output logic [SEC_W-1:0]          sys_sec,
    output logic [ptp_pkg::SUB_W-1:0] sys_sub,
    output logic                      init_busy,
    output logic                      update_busy,
    output logic                      addend_busy,
    output logic                      trig_armed,
    output logic                      trig_irq
);

    import ptp_pkg::*;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
        logic             init_p;
        logic             upd_p;
        logic             add_p;
    } time_t;

    time_t            st_d, st_q;
    logic [INC_W-1:0] step;
    wrap_t            w_inc, w_add, w_sub;
    logic [SUB_W-1:0] off_sub;

    ptp_step_gen #(.ACC_W(ACC_W), .INC_W(INC_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (time_en & fine_mode),
        .fine      (fine_mode),
        .load      (st_q.add_p),
        .addend_in (addend_in),
        .sub_inc   (sub_inc),
        .step      (step)
    );

    ptp_trigger #(.SEC_W(SEC_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (trig_req),
        .cur_sec (st_q.sec),
        .cur_sub (st_q.sub),
        .tgt_sec (target_sec),
        .tgt_sub (target_sub),
        .armed   (trig_armed),
        .irq     (trig_irq)
    );

    always_comb begin
        st_d    = st_q;
        off_sub = set_sub[SUB_W-1:0];
        w_inc   = wrap_add(st_q.sub, SUB_W'(step), dec_rollover);
        w_add   = wrap_add(st_q.sub, off_sub, dec_rollover);
        w_sub   = wrap_sub(st_q.sub, off_sub, dec_rollover);

        // each request flag lives one cycle; a repeat while set is dropped
        st_d.init_p = st_q.init_p ? 1'b0 : init_req;
        st_d.upd_p  = st_q.upd_p  ? 1'b0 : update_req;
        st_d.add_p  = st_q.add_p  ? 1'b0 : addend_req;

        if (st_q.init_p) begin
            st_d.sec = set_sec;
            st_d.sub = off_sub;
        end else if (st_q.upd_p) begin
            if (set_sub[SUB_W]) begin
                st_d.sub = w_sub.val;
                st_d.sec = st_q.sec - set_sec - SEC_W'(w_sub.carry);
            end else begin
                st_d.sub = w_add.val;
                st_d.sec = st_q.sec + set_sec + SEC_W'(w_add.carry);
            end
        end else if (time_en) begin
            st_d.sub = w_inc.val;
            st_d.sec = st_q.sec + SEC_W'(w_inc.carry);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_sec     = st_q.sec;
    assign sys_sub     = st_q.sub;
    assign init_busy   = st_q.init_p;
    assign update_busy = st_q.upd_p;
    assign addend_busy = st_q.add_p;

endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk #(
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             time_en,
    input logic             init_busy,
    input logic             update_busy,
    input logic             addend_busy,
    input logic             trig_armed,
    input logic             trig_irq,
    input logic [SEC_W-1:0] set_sec,
    input logic [31:0]      set_sub,
    input logic [SEC_W-1:0] sys_sec,
    input logic [30:0]      sys_sub
);

    assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> !init_busy);

    assert_update_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        update_busy |=> !update_busy);

    assert_addend_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addend_busy |=> !addend_busy);

    assert_init_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> (sys_sec == $past(set_sec) && sys_sub == $past(set_sub[30:0])));

    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_en && !init_busy && !update_busy) |=> ($stable(sys_sec) && $stable(sys_sub)));

    assert_irq_disarms_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> (!trig_armed && $past(trig_armed)));

endmodule

bind ptp_systime ptp_systime_chk #(.SEC_W(SEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_en     (time_en),
    .init_busy   (init_busy),
    .update_busy (update_busy),
    .addend_busy (addend_busy),
    .trig_armed  (trig_armed),
    .trig_irq    (trig_irq),
    .set_sec     (set_sec),
    .set_sub     (set_sub),
    .sys_sec     (sys_sec),
    .sys_sub     (sys_sub)
);

// File: tb/tb_ptp_systime.sv
module tb_ptp_systime;

    localparam int CLK_PERIOD = 10;
    localparam longint M32 = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        time_en = 1'b0, dec_rollover = 1'b0, fine_mode = 1'b0;
    logic        init_req = 1'b0, update_req = 1'b0, addend_req = 1'b0, trig_req = 1'b0;
    logic [31:0] set_sec = '0, set_sub = '0, addend_in = '0, target_sec = '0;
    logic [7:0]  sub_inc = '0;
    logic [30:0] target_sub = '0;
    logic [31:0] sys_sec;
    logic [30:0] sys_sub;
    logic        init_busy, update_busy, addend_busy, trig_armed, trig_irq;

    int    errors = 0;
    int    checks = 0;
    bit    running = 0;
    string cur_req = "R1";

    longint m_sec = 0, m_sub = 0, m_acc = 0, m_add = 0;
    bit     m_ip = 0, m_up = 0, m_ap = 0, m_arm = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_systime dut (
        .clk(clk), .rst_n(rst_n), .time_en(time_en), .dec_rollover(dec_rollover),
        .fine_mode(fine_mode), .init_req(init_req), .update_req(update_req),
        .addend_req(addend_req), .trig_req(trig_req), .set_sec(set_sec),
        .set_sub(set_sub), .addend_in(addend_in), .sub_inc(sub_inc),
        .target_sec(target_sec), .target_sub(target_sub), .sys_sec(sys_sec),
        .sys_sub(sys_sub), .init_busy(init_busy), .update_busy(update_busy),
        .addend_busy(addend_busy), .trig_armed(trig_armed), .trig_irq(trig_irq)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        longint span, s, sec_n, sub_n, off, acc_n, add_n, stp;
        bit     cy, fire;
        if (!rst_n) begin
            m_sec = 0; m_sub = 0; m_acc = 0; m_add = 0;
            m_ip = 0; m_up = 0; m_ap = 0; m_arm = 0; m_irq = 0;
        end else begin
            span  = dec_rollover ? 64'd1000000000 : 64'h8000_0000;
            cy    = (m_acc + m_add) > M32;
            acc_n = (time_en && fine_mode) ? ((m_acc + m_add) & M32) : m_acc;
            stp   = (fine_mode && !cy) ? 0 : longint'(sub_inc);
            sec_n = m_sec; sub_n = m_sub;
            off   = longint'(set_sub[30:0]);
            if (m_ip) begin
                sec_n = longint'(set_sec); sub_n = off;
            end else if (m_up) begin
                if (set_sub[31]) begin
                    if (m_sub >= off) begin
                        sub_n = m_sub - off; sec_n = (m_sec - set_sec) & M32;
                    end else begin
                        sub_n = m_sub + span - off; sec_n = (m_sec - set_sec - 1) & M32;
                    end
                end else begin
                    s = m_sub + off;
                    sec_n = m_sec + set_sec;
                    if (s >= span) begin s = s - span; sec_n = sec_n + 1; end
                    sub_n = s; sec_n = sec_n & M32;
                end
            end else if (time_en) begin
                s = m_sub + stp;
                if (s >= span) begin s = s - span; sec_n = (m_sec + 1) & M32; end
                sub_n = s;
            end
            add_n = m_ap ? longint'(addend_in) : m_add;
            fire  = m_arm && ((m_sec > target_sec) || (m_sec == target_sec && m_sub > target_sub));
            m_arm = m_arm ? !fire : trig_req;
            m_irq = fire;
            m_ip  = m_ip ? 0 : init_req;
            m_up  = m_up ? 0 : update_req;
            m_ap  = m_ap ? 0 : addend_req;
            m_sec = sec_n; m_sub = sub_n; m_acc = acc_n; m_add = add_n;
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (running) begin
            check(cur_req, "sys_sec", sys_sec, m_sec);
            check(cur_req, "sys_sub", sys_sub, m_sub);
            check(cur_req, "init_busy", init_busy, m_ip);
            check(cur_req, "update_busy", update_busy, m_up);
            check(cur_req, "addend_busy", addend_busy, m_ap);
            check(cur_req, "trig_armed", trig_armed, m_arm);
            check(cur_req, "trig_irq", trig_irq, m_irq);
        end
    end

    task automatic do_init(input longint sec, input longint sub);
        @(negedge clk);
        set_sec = sec[31:0]; set_sub = sub[31:0]; init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        check("R8", "init_busy set", init_busy, 1);
        @(negedge clk);
        check("R8", "init_busy cleared", init_busy, 0);
        check("R8", "loaded sec", sys_sec, sec);
        check("R8", "loaded sub", sys_sub, sub & 64'h7FFF_FFFF);
    endtask

    task automatic do_update(input longint sec, input longint sub);
        @(negedge clk);
        set_sec = sec[31:0]; set_sub = sub[31:0]; update_req = 1'b1;
        @(negedge clk);
        update_req = 1'b0;
        check("R9", "update_busy set", update_busy, 1);
        @(negedge clk);
        check("R9", "update_busy cleared", update_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        longint hold_s, hold_c;
        int     pulses;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "sys_sec", sys_sec, 0);
        check("R1", "sys_sub", sys_sub, 0);
        check("R1", "flags", {init_busy, update_busy, addend_busy, trig_armed, trig_irq}, 0);
        rst_n = 1'b1;
        running = 1;

        // R2: coarse stepping
        cur_req = "R2";
        sub_inc = 8'd10;
        do_init(0, 0);
        time_en = 1'b1;
        repeat (6) @(negedge clk);
        check("R2", "six coarse steps", sys_sub, 60);

        // R3: binary wrap
        cur_req = "R3";
        do_init(5, 64'h7FFF_FFF0);
        repeat (2) @(negedge clk);
        check("R3", "sec after binary wrap", sys_sec, 6);
        check("R3", "sub after binary wrap", sys_sub, 4);

        // R4: decimal wrap
        cur_req = "R4";
        dec_rollover = 1'b1;
        do_init(7, 999999990);
        @(negedge clk);
        check("R4", "sec after decimal wrap", sys_sec, 8);
        check("R4", "sub after decimal wrap", sys_sub, 0);
        repeat (5) @(negedge clk);

        // R5: suspended
        cur_req = "R5";
        time_en = 1'b0;
        hold_s = sys_sec; hold_c = sys_sub;
        repeat (5) @(negedge clk);
        check("R5", "sec held", sys_sec, hold_s);
        check("R5", "sub held", sys_sub, hold_c);

        // R7 / R6: addend load then fine stepping
        cur_req = "R7";
        fine_mode = 1'b1;
        addend_in = 32'h4000_0000;
        addend_req = 1'b1;
        @(negedge clk);
        addend_req = 1'b0;
        check("R7", "addend_busy set", addend_busy, 1);
        @(negedge clk);
        check("R7", "addend_busy cleared", addend_busy, 0);
        cur_req = "R6";
        sub_inc = 8'd100;
        do_init(0, 0);
        time_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R6", "fine steps after eight edges", sys_sub, 200);
        check("R7", "loaded addend gives quarter rate", sys_sub, 200);
        repeat (20) @(negedge clk);
        fine_mode = 1'b0;

        // R11: repeated request while pending
        cur_req = "R11";
        sub_inc = 8'd10;
        @(negedge clk);
        set_sec = 20; set_sub = 1000; init_req = 1'b1;
        @(negedge clk);
        set_sec = 30; set_sub = 5000;
        @(negedge clk);
        init_req = 1'b0;
        check("R11", "first load taken", sys_sub, 5000);
        check("R11", "repeat not pending", init_busy, 0);
        @(negedge clk);
        check("R11", "no second load", sys_sub, 5010);

        // R9: add offset with carry
        cur_req = "R9";
        time_en = 1'b0;
        do_init(10, 999999000);
        do_update(3, 2000);
        check("R9", "sec after add", sys_sec, 14);
        check("R9", "sub after add", sys_sub, 1000);

        // R10: subtract with borrow, decimal then binary
        cur_req = "R10";
        do_update(2, 64'h8000_0000 | 3000);
        check("R10", "sec after subtract", sys_sec, 11);
        check("R10", "sub after subtract", sys_sub, 999998000);
        dec_rollover = 1'b0;
        do_init(4, 16);
        do_update(1, 64'h8000_0000 | 32);
        check("R10", "binary borrow sec", sys_sec, 2);
        check("R10", "binary borrow sub", sys_sub, 64'h7FFF_FFF0);
        dec_rollover = 1'b1;

        // R12: load and offset in the same cycle
        cur_req = "R12";
        @(negedge clk);
        set_sec = 50; set_sub = 7; init_req = 1'b1; update_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0; update_req = 1'b0;
        @(negedge clk);
        check("R12", "load wins sec", sys_sec, 50);
        check("R12", "offset dropped", update_busy, 0);
        @(negedge clk);
        check("R12", "no late offset", sys_sec, 50);
        check("R12", "sub unchanged", sys_sub, 7);

        // R13: target-time alarm
        cur_req = "R13";
        target_sec = 100; target_sub = 25;
        do_init(100, 0);
        time_en = 1'b1;
        trig_req = 1'b1;
        @(negedge clk);
        trig_req = 1'b0;
        check("R13", "armed", trig_armed, 1);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (trig_irq) pulses++;
        end
        check("R13", "single irq pulse", pulses, 1);
        check("R13", "disarmed", trig_armed, 0);

        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule